// File: doc/BRIEF.md
# Signalling-Channel Contention Arbiter

This block sits on the terminal side of a shared signalling channel. Several terminals drive one D bit line, and the network echoes every D bit back on a separate E bit. The arbiter decides when this terminal may begin sending a packet and when it must give up. Each echoed 1 advances a priority counter and each echoed 0 clears it. When the counter reaches the active terminal count while a packet is waiting, the block raises its transmit enable. The framer then starts the packet with its opening flag.

The terminal count is chosen at two levels. The class input picks the high-priority pair (8 or 9) or the low-priority pair (10 or 11). An internal level then picks one value from that pair. After a packet completes successfully, the internal level drops to the larger count. It returns to the smaller count once the counter has climbed to the larger value. While sending, the block compares each D bit it sends with the echo for that bit. On a mismatch it stops at once, pulses an interrupt and a FIFO flush, and starts counting again. The acknowledge bit is cleared at the following frame pulse.

Top module: `dch_access_arb`

## Requirements
- R1: After reset, tx_en, chan_ack, coll_irq and flush_req are all 0, the counter is zero and the internal level is the higher-priority (smaller) count.
- R2: In counting, each bit_strobe with e_bit=1 adds one to the counter. If the new count is at least the terminal count and tx_req=1, tx_en is 1 from the cycle after that strobe.
- R3: A bit_strobe with e_bit=0 during counting sets the counter to zero.
- R4: class_low=0 selects terminal count 8 (or 9 at the lower internal level). class_low=1 selects 10 (or 11 at the lower level). The class always decides the pair.
- R5: Without tx_req the counter keeps advancing and saturates, and no grant occurs. If tx_req is raised later, the next strobe with e_bit=1 grants.
- R6: A pkt_done while sending, with no collision in that cycle, moves the internal level to the larger count of the class. The level returns to the smaller count when the counter reaches that larger count during counting.
- R7: While sending, a strobe whose e_bit equals d_tx_bit keeps tx_en at 1 and the counter stays at zero. A strobe whose e_bit differs from d_tx_bit is a collision, and tx_en is 0 from the next cycle.
- R8: A collision makes coll_irq and flush_req 1 for exactly the one cycle after the collision strobe.
- R9: chan_ack becomes 1 together with tx_en at a grant. After a successful pkt_done it returns to 0 together with tx_en.
- R10: After a collision, chan_ack stays 1 until the next frame_pulse and is 0 after it. Counting restarts from zero with the internal level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_strobe | input | 1 | One-cycle strobe marking a valid D/E bit pair |
| e_bit | input | 1 | Echoed bit for the current position |
| d_tx_bit | input | 1 | D bit this terminal sent for the current position |
| frame_pulse | input | 1 | Frame boundary strobe |
| tx_req | input | 1 | A packet is waiting in the transmit FIFO |
| pkt_done | input | 1 | Framer reports the closing of the current packet |
| class_low | input | 1 | Priority class: 0 high, 1 low |
| tx_en | output | 1 | Permission to drive the D channel |
| coll_irq | output | 1 | One-cycle collision interrupt pulse |
| chan_ack | output | 1 | Channel-acknowledge status |
| flush_req | output | 1 | One-cycle request to discard the rest of the packet |

## Verification
The assertions assume that bit_strobe, pkt_done and frame_pulse are single-cycle strobes. They also assume that tx_req is not withdrawn in the cycle of a grant, and that the framer reports pkt_done only while tx_en is 1. The stimulus drives every strobe for exactly one cycle, separated by idle cycles. It changes tx_req and class_low only between strobes, and raises pkt_done only after a grant, so the checks stay inside these assumptions. The corner cases covered are the exact strobe at which each terminal count is reached, a zero breaking a run, saturation without a request, the level swap after success and its recovery, and a collision followed by the frame pulse and a new count.

// File: rtl/dch_pkg.sv
// Package: shared types and helpers for the signalling-channel arbiter.
// Assumes nothing beyond a count width large enough for the low-class maximum.
package dch_pkg;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_SEND  = 1'b1
    } dch_state_e;

endpackage

// File: rtl/dch_prio_counter.sv
// Priority counter: counts consecutive echoed ones, clears on a zero,
// saturates at its maximum, is held while sending and can be forced to zero.
// Assumes strobe lasts one cycle per bit pair.
module dch_prio_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             e_bit,
    input  logic             hold,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Next value for a counting strobe: increment with saturation, or clear.
    always_comb begin
        if (!e_bit)
            cnt_nxt = '0;
        else if (cnt == CNT_MAX)
            cnt_nxt = cnt;
        else
            cnt_nxt = cnt + 1'b1;
    end

    // Counter register: forced clear wins, otherwise update on a live strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (strobe && !hold)
            cnt <= cnt_nxt;
    end

    // R5: a saturated counter stays saturated on a further echoed one
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && strobe && !hold && !clear && e_bit) |=> (cnt == CNT_MAX));

    // R3: a zero echo while counting leaves the counter at zero
    a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !hold && !e_bit) |=> (cnt == '0));
endmodule

// File: rtl/dch_term_select.sv
// Terminal-count selector: the class picks the pair, the internal level picks
// the member. The level drops after a successful packet and recovers once the
// counter reaches the larger count. Assumes HI_BASE < LO_BASE and LO_BASE+1 fits CNT_W.
module dch_term_select #(
    parameter int CNT_W   = 4,
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             class_low,
    input  logic             set_low,
    input  logic             count_strobe,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] term
);
    localparam logic [CNT_W-1:0] HI_T = CNT_W'(HI_BASE);
    localparam logic [CNT_W-1:0] LO_T = CNT_W'(LO_BASE);

    logic             lvl_low;
    logic [CNT_W-1:0] base;

    // Active count: class base plus one when at the lower internal level.
    always_comb begin
        base = class_low ? LO_T : HI_T;
        term = base + {{(CNT_W-1){1'b0}}, lvl_low};
    end

    // Internal level: set on success, cleared when the larger count is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_low <= 1'b0;
        else if (set_low)
            lvl_low <= 1'b1;
        else if (count_strobe && (cnt_nxt >= base + 1'b1))
            lvl_low <= 1'b0;
    end

    // R6: after a success the level is the lower one in the next cycle
    a_r6_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
        set_low |=> lvl_low);

    // R4: the class alone chooses the pair
    a_r4_pair: assert property (@(posedge clk) disable iff (!rst_n)
        class_low ? (term >= LO_T) : (term <= HI_T + 1'b1));
endmodule

// File: rtl/dch_coll_detect.sv
// Collision detector: while sending, flags any strobe whose echo differs from
// the bit this terminal put on the line. Assumes d_tx_bit is valid with strobe.
module dch_coll_detect (
    input  logic strobe,
    input  logic sending,
    input  logic d_tx_bit,
    input  logic e_bit,
    output logic coll
);
    // Mismatch between the sent bit and its echo on a live strobe.
    always_comb coll = strobe && sending && (d_tx_bit != e_bit);
endmodule

// File: rtl/dch_access_arb.sv
// Access arbiter top: counts echoed ones, grants the D channel at the active
// terminal count, aborts on collision and manages the acknowledge status.
// Assumes single-cycle strobes and pkt_done only while sending.
module dch_access_arb #(
    parameter int CNT_W   = 4,
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_strobe,
    input  logic e_bit,
    input  logic d_tx_bit,
    input  logic frame_pulse,
    input  logic tx_req,
    input  logic pkt_done,
    input  logic class_low,
    output logic tx_en,
    output logic coll_irq,
    output logic chan_ack,
    output logic flush_req
);
    import dch_pkg::*;

    dch_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] term;
    logic             count_strobe;
    logic             grant;
    logic             coll;
    logic             done_ok;
    logic             cnt_clear;
    logic             coll_pend;

    // Decode of the events that drive the state machine.
    always_comb begin
        count_strobe = bit_strobe && (state == ST_COUNT);
        grant        = count_strobe && tx_req && (cnt_nxt >= term);
        done_ok      = (state == ST_SEND) && pkt_done && !coll;
        cnt_clear    = grant || coll || done_ok;
    end

    dch_prio_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (bit_strobe),
        .e_bit   (e_bit),
        .hold    (state == ST_SEND),
        .clear   (cnt_clear),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    dch_term_select #(.CNT_W(CNT_W), .HI_BASE(HI_BASE), .LO_BASE(LO_BASE)) u_term (
        .clk          (clk),
        .rst_n        (rst_n),
        .class_low    (class_low),
        .set_low      (done_ok),
        .count_strobe (count_strobe),
        .cnt_nxt      (cnt_nxt),
        .term         (term)
    );

    dch_coll_detect u_coll (
        .strobe   (bit_strobe),
        .sending  (state == ST_SEND),
        .d_tx_bit (d_tx_bit),
        .e_bit    (e_bit),
        .coll     (coll)
    );

    // State register: enter sending on grant, leave on collision or success.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_COUNT;
        else if (state == ST_COUNT && grant)
            state <= ST_SEND;
        else if (state == ST_SEND && (coll || done_ok))
            state <= ST_COUNT;
    end

    // Collision pulses: interrupt and FIFO flush for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_irq  <= 1'b0;
            flush_req <= 1'b0;
        end else begin
            coll_irq  <= coll;
            flush_req <= coll;
        end
    end

    // Acknowledge status: set at grant, cleared at success or frame after collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_ack  <= 1'b0;
            coll_pend <= 1'b0;
        end else if (grant) begin
            chan_ack  <= 1'b1;
            coll_pend <= 1'b0;
        end else if (done_ok) begin
            chan_ack  <= 1'b0;
        end else if (coll) begin
            coll_pend <= 1'b1;
        end else if (frame_pulse && coll_pend) begin
            chan_ack  <= 1'b0;
            coll_pend <= 1'b0;
        end
    end

    assign tx_en = (state == ST_SEND);

    // R7: a collision strobe removes transmit permission in the next cycle
    a_r7_coll_stops: assert property (@(posedge clk) disable iff (!rst_n)
        coll |=> !tx_en);

    // R7: the counter is held at zero throughout sending
    a_r7_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (cnt == '0));

    // R8: the flush request never lasts more than one cycle
    a_r8_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);

    // R9: permission is never held without the acknowledge bit
    a_r9_ack_with_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> chan_ack);

    // R2: a grant only follows a pending request
    a_r2_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(tx_req));
endmodule

// File: tb/tb_dch_access_arb.sv
module tb_dch_access_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_strobe = 1'b0, e_bit = 1'b0, d_tx_bit = 1'b0;
    logic frame_pulse = 1'b0, tx_req = 1'b0, pkt_done = 1'b0, class_low = 1'b0;
    logic tx_en, coll_irq, chan_ack, flush_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dch_access_arb dut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .e_bit(e_bit),
        .d_tx_bit(d_tx_bit), .frame_pulse(frame_pulse), .tx_req(tx_req),
        .pkt_done(pkt_done), .class_low(class_low), .tx_en(tx_en),
        .coll_irq(coll_irq), .chan_ack(chan_ack), .flush_req(flush_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_strobe = 0; pkt_done = 0; frame_pulse = 0; tx_req = 0; class_low = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One strobe with the given echo and sent bit; returns at the sampling negedge.
    task automatic send_bit(input logic e, input logic d);
        @(negedge clk);
        bit_strobe = 1'b1; e_bit = e; d_tx_bit = d;
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 1'b1);
    endtask

    task automatic finish_pkt();
        @(negedge clk);
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tx_en", tx_en, 1'b0);
        chk("R1 chan_ack", chan_ack, 1'b0);
        chk("R1 coll_irq", coll_irq, 1'b0);
        chk("R1 flush_req", flush_req, 1'b0);
    endtask

    task automatic t_high_grant();
        do_reset();
        tx_req = 1'b1;
        ones(7);
        chk("R2 no grant at 7", tx_en, 1'b0);
        ones(1);
        chk("R2 grant at 8", tx_en, 1'b1);
        chk("R9 ack at grant", chan_ack, 1'b1);
    endtask

    task automatic t_zero_clears();
        do_reset();
        tx_req = 1'b1;
        ones(6);
        send_bit(1'b0, 1'b1);
        ones(7);
        chk("R3 run broken by zero", tx_en, 1'b0);
        ones(1);
        chk("R3 grant after fresh 8", tx_en, 1'b1);
    endtask

    task automatic t_low_class();
        do_reset();
        class_low = 1'b1; tx_req = 1'b1;
        ones(9);
        chk("R4 low class no grant at 9", tx_en, 1'b0);
        ones(1);
        chk("R4 low class grant at 10", tx_en, 1'b1);
    endtask

    task automatic t_no_req();
        do_reset();
        ones(20);
        chk("R5 no grant without request", tx_en, 1'b0);
        tx_req = 1'b1;
        ones(1);
        chk("R5 grant on next one after request", tx_en, 1'b1);
    endtask

    task automatic t_success_level();
        do_reset();
        tx_req = 1'b1;
        ones(8);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        chk("R7 matching echoes keep sending", tx_en, 1'b1);
        finish_pkt();
        chk("R9 tx_en low after success", tx_en, 1'b0);
        chk("R9 ack low after success", chan_ack, 1'b0);
        ones(8);
        chk("R6 lower level no grant at 8", tx_en, 1'b0);
        ones(1);
        chk("R6 lower level grant at 9", tx_en, 1'b1);
        finish_pkt();
        class_low = 1'b1;
        ones(10);
        chk("R6 low class lower level no grant at 10", tx_en, 1'b0);
        ones(1);
        chk("R6 low class lower level grant at 11", tx_en, 1'b1);
    endtask

    task automatic t_level_return();
        do_reset();
        tx_req = 1'b1;
        ones(8);
        finish_pkt();
        tx_req = 1'b0;
        ones(9);
        send_bit(1'b0, 1'b0);
        tx_req = 1'b1;
        ones(7);
        chk("R6 recovered level no grant at 7", tx_en, 1'b0);
        ones(1);
        chk("R6 recovered level grant at 8", tx_en, 1'b1);
    endtask

    task automatic t_collision();
        do_reset();
        tx_req = 1'b1;
        ones(8);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        chk("R7 tx_en drops on collision", tx_en, 1'b0);
        chk("R8 coll_irq pulse", coll_irq, 1'b1);
        chk("R8 flush_req pulse", flush_req, 1'b1);
        chk("R10 ack held until frame", chan_ack, 1'b1);
        @(negedge clk);
        chk("R8 coll_irq one cycle", coll_irq, 1'b0);
        chk("R8 flush_req one cycle", flush_req, 1'b0);
        chk("R10 ack still held", chan_ack, 1'b1);
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        chk("R10 ack cleared at frame", chan_ack, 1'b0);
        ones(7);
        chk("R10 restart from zero no grant at 7", tx_en, 1'b0);
        ones(1);
        chk("R10 level unchanged grant at 8", tx_en, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_high_grant();
                t_zero_clears();
                t_low_class();
                t_no_req();
                t_success_level();
                t_level_return();
                t_collision();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule